// File: doc/BRIEF.md
# Open-Row DRAM Array Model

A synthesizable behavioural model of one DRAM-style bank. The store is a grid of rows by columns of words, and every bit of a word sits on its own plane behind the same row and column address. A single row buffer holds whichever row is currently open. Requests come in over a valid/ready handshake and carry a read or write flag, a row, a column and write data. Each access runs a row phase and then a column phase. The row phase activates the row by copying it into the buffer. The column phase reads or updates one word of the buffer.

Activation destroys the copy in the array, so the buffer must be written back (precharge) before another row can be opened. When a request targets the row that is already open, the row phase is skipped, which gives a much shorter latency. A built-in refresh timer makes the model activate and restore every row in turn. Refresh wins over user traffic at the next idle point and leaves the bank with no row open.

Top module: `openrow_dram`

## Requirements
- R1: After reset, reqReady is 1, rspValid is 0 and rspRdata is 0. No row is open, and every stored word reads back as 0.
- R2: A request to the open row makes reqReady low for exactly one cycle after the accepting edge. rspValid pulses in the cycle that follows.
- R3: A request made while no row is open makes reqReady low for ACT_CYCLES+1 cycles, and rspValid pulses right after them.
- R4: A request to a different row while a row is open makes reqReady low for PRE_CYCLES+ACT_CYCLES+1 cycles. The old row's contents, including earlier writes, survive in the array.
- R5: A row is activated only while no row is open, and never in the same cycle as a write-back. Only one row line is driven at a time.
- R6: A read returns the last value written to that row and column, whether or not the row has been closed and reopened since.
- R7: A refresh becomes pending every REFRESH_INTERVAL cycles. At the next idle point it takes priority over a waiting request and keeps reqReady low for PRE_CYCLES (only if a row was open) + ACT_CYCLES + PRE_CYCLES cycles. It leaves no row open, loses no data, and visits rows in ascending order with wrap-around.
- R8: rspValid is a one-cycle pulse that ends every read and every write. rspRdata changes only when a read completes, and holds its value otherwise.
- R9: reqWrite, reqRow, reqCol and reqWdata are sampled only at an edge where reqValid and reqReady are both 1. A request presented while reqReady is 0 leaves no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Model can accept a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqRow | input | $clog2(ROWS) | Row address |
| reqCol | input | $clog2(COLS) | Column address |
| reqWdata | input | WIDTH | Write data |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | WIDTH | Data of the most recent completed read |

## Verification
The assertions check several rules on every cycle. A row is activated only while the bank is closed, and a write-back happens only while a row is open. An accepted request always drops reqReady on the next cycle. The completion pulse never lasts two cycles. The refresh pointer moves only when a refresh finishes. The bench's cycle-by-cycle reference model covers what needs a history: the latencies of hits, closed misses, open misses and refresh, refresh winning over a waiting request, data surviving write-backs and refreshes, and requests presented while busy being ignored.

// File: rtl/dram_pkg.sv
package dram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_ACT,
    PH_COL,
    PH_RPRE
  } phase_e;

  typedef struct packed {
    logic capture;
    logic loadRow;
    logic writeBack;
    logic colWrite;
    logic colRead;
  } strobe_t;

endpackage

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_pkg::*;
#(
  parameter int ROWS             = 16,
  parameter int COLS             = 8,
  parameter int ACT_CYCLES       = 3,
  parameter int PRE_CYCLES       = 2,
  parameter int REFRESH_INTERVAL = 256
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqWrite,
  input  logic [$clog2(ROWS)-1:0] reqRow,
  input  logic [$clog2(COLS)-1:0] reqCol,
  output strobe_t                 stb,
  output logic [$clog2(ROWS)-1:0] actRow,
  output logic [$clog2(ROWS)-1:0] openRowIdx,
  output logic [$clog2(COLS)-1:0] colIdx
);

  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam int MAXC  = (ACT_CYCLES > PRE_CYCLES) ? ACT_CYCLES : PRE_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int REF_W = $clog2(REFRESH_INTERVAL);

  phase_e             phase;
  logic [CNT_W-1:0]   cnt;
  logic               rowOpen;
  logic [ROW_W-1:0]   openRowQ;
  logic [ROW_W-1:0]   rowQ;
  logic [COL_W-1:0]   colQ;
  logic               writeQ;
  logic               refBusy;
  logic               refPending;
  logic [REF_W-1:0]   refCnt;
  logic [ROW_W-1:0]   refPtr;
  logic               phaseEnd;

  assign phaseEnd   = (cnt == '0);
  assign reqReady   = (phase == PH_IDLE) && !refPending;
  assign actRow     = refBusy ? refPtr : rowQ;
  assign openRowIdx = openRowQ;
  assign colIdx     = colQ;

  always_comb begin
    stb.capture   = reqValid && reqReady;
    stb.loadRow   = (phase == PH_ACT) && phaseEnd;
    stb.writeBack = ((phase == PH_PRE) || (phase == PH_RPRE)) && phaseEnd;
    stb.colWrite  = (phase == PH_COL) && writeQ;
    stb.colRead   = (phase == PH_COL) && !writeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      rowOpen    <= 1'b0;
      openRowQ   <= '0;
      rowQ       <= '0;
      colQ       <= '0;
      writeQ     <= 1'b0;
      refBusy    <= 1'b0;
      refPending <= 1'b0;
      refCnt     <= '0;
      refPtr     <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (refPending) begin
            refBusy    <= 1'b1;
            refPending <= 1'b0;
            if (rowOpen) begin
              phase <= PH_PRE;
              cnt   <= CNT_W'(PRE_CYCLES - 1);
            end else begin
              phase <= PH_ACT;
              cnt   <= CNT_W'(ACT_CYCLES - 1);
            end
          end else if (reqValid) begin
            rowQ   <= reqRow;
            colQ   <= reqCol;
            writeQ <= reqWrite;
            if (rowOpen && (openRowQ == reqRow)) begin
              phase <= PH_COL;
            end else if (rowOpen) begin
              phase <= PH_PRE;
              cnt   <= CNT_W'(PRE_CYCLES - 1);
            end else begin
              phase <= PH_ACT;
              cnt   <= CNT_W'(ACT_CYCLES - 1);
            end
          end
        end
        PH_PRE: begin
          if (phaseEnd) begin
            rowOpen <= 1'b0;
            phase   <= PH_ACT;
            cnt     <= CNT_W'(ACT_CYCLES - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_ACT: begin
          if (phaseEnd) begin
            rowOpen  <= 1'b1;
            openRowQ <= actRow;
            if (refBusy) begin
              phase <= PH_RPRE;
              cnt   <= CNT_W'(PRE_CYCLES - 1);
            end else begin
              phase <= PH_COL;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_COL: phase <= PH_IDLE;
        PH_RPRE: begin
          if (phaseEnd) begin
            rowOpen <= 1'b0;
            refBusy <= 1'b0;
            refPtr  <= (refPtr == ROW_W'(ROWS - 1)) ? '0 : refPtr + 1'b1;
            phase   <= PH_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase

      if (refCnt == REF_W'(REFRESH_INTERVAL - 1)) begin
        refCnt     <= '0;
        refPending <= 1'b1;
      end else begin
        refCnt <= refCnt + 1'b1;
      end
    end
  end

  // R5: activation only into a closed bank
  a_r5_act_when_closed: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadRow |-> !rowOpen);

  // R4: a write-back always has an open row to restore
  a_r4_wb_when_open: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeBack |-> rowOpen);

  // R2: an accepted request always makes the model busy for at least one cycle
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R7: the refresh pointer only moves when a refresh finishes
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !((phase == PH_RPRE) && phaseEnd) |=> $stable(refPtr));

endmodule

// File: rtl/dram_datapath.sv
module dram_datapath
  import dram_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int COLS  = 8,
  parameter int WIDTH = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [$clog2(ROWS)-1:0] actRow,
  input  logic [$clog2(ROWS)-1:0] openRowIdx,
  input  logic [$clog2(COLS)-1:0] colIdx,
  input  logic [WIDTH-1:0]        reqWdata,
  output logic [WIDTH-1:0]        rdata,
  output logic                    done
);

  // each word is WIDTH parallel bit planes sharing one row/column address
  logic [WIDTH-1:0] cells  [ROWS][COLS];
  logic [WIDTH-1:0] rowBuf [COLS];
  logic [WIDTH-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          cells[r][c] <= '0;
      for (int c = 0; c < COLS; c++)
        rowBuf[c] <= '0;
      wdataQ <= '0;
      rdata  <= '0;
      done   <= 1'b0;
    end else begin
      done <= stb.colWrite || stb.colRead;
      if (stb.capture)
        wdataQ <= reqWdata;
      if (stb.loadRow) begin
        // sensing empties the cells: the buffer now holds the only copy
        for (int c = 0; c < COLS; c++) begin
          rowBuf[c]        <= cells[actRow][c];
          cells[actRow][c] <= '0;
        end
      end
      if (stb.writeBack) begin
        for (int c = 0; c < COLS; c++)
          cells[openRowIdx][c] <= rowBuf[c];
      end
      if (stb.colWrite)
        rowBuf[colIdx] <= wdataQ;
      if (stb.colRead)
        rdata <= rowBuf[colIdx];
    end
  end

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/openrow_dram.sv
module openrow_dram
  import dram_pkg::*;
#(
  parameter int ROWS             = 16,
  parameter int COLS             = 8,
  parameter int WIDTH            = 8,
  parameter int ACT_CYCLES       = 3,
  parameter int PRE_CYCLES       = 2,
  parameter int REFRESH_INTERVAL = 256
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic                    reqWrite,
  input  logic [$clog2(ROWS)-1:0] reqRow,
  input  logic [$clog2(COLS)-1:0] reqCol,
  input  logic [WIDTH-1:0]        reqWdata,
  output logic                    rspValid,
  output logic [WIDTH-1:0]        rspRdata
);

  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);

  strobe_t          stb;
  logic [ROW_W-1:0] actRow;
  logic [ROW_W-1:0] openRowIdx;
  logic [COL_W-1:0] colIdx;

  dram_ctrl #(
    .ROWS(ROWS), .COLS(COLS), .ACT_CYCLES(ACT_CYCLES),
    .PRE_CYCLES(PRE_CYCLES), .REFRESH_INTERVAL(REFRESH_INTERVAL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqRow(reqRow), .reqCol(reqCol), .stb(stb),
    .actRow(actRow), .openRowIdx(openRowIdx), .colIdx(colIdx)
  );

  dram_datapath #(
    .ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .actRow(actRow),
    .openRowIdx(openRowIdx), .colIdx(colIdx), .reqWdata(reqWdata),
    .rdata(rspRdata), .done(rspValid)
  );

endmodule

// File: tb/tb_openrow_dram.sv
module tb_openrow_dram;

  localparam int ROWS = 16;
  localparam int COLS = 8;
  localparam int WIDTH = 8;
  localparam int ACT = 3;
  localparam int PRE = 2;
  localparam int INTV = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [3:0] reqRow = '0;
  logic [2:0] reqCol = '0;
  logic [WIDTH-1:0] reqWdata = '0;
  logic reqReady;
  logic rspValid;
  logic [WIDTH-1:0] rspRdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  openrow_dram #(
    .ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH), .ACT_CYCLES(ACT),
    .PRE_CYCLES(PRE), .REFRESH_INTERVAL(INTV)
  ) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqRow(reqRow), .reqCol(reqCol),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspRdata(rspRdata)
  );

  // behavioural reference: flat word store plus a busy countdown
  int    mem [ROWS][COLS];
  int    busy = 0;
  bit    pend = 0;
  bit    open = 0;
  int    oRow = 0;
  bit    userOp = 0;
  bit    opWrite = 0;
  int    opData = 0;
  int    tick = 0;
  bit    readyE = 1;
  bit    doneE = 0;
  int    rdataE = 0;
  string ctxTag = "R1";
  string phaseTag = "R1";

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        mem[r][c] = 0;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      busy = 0; pend = 0; open = 0; userOp = 0; tick = 0;
      readyE = 1; doneE = 0; rdataE = 0; ctxTag = "R1";
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          mem[r][c] = 0;
    end else begin
      doneE = 0;
      if (busy > 0) begin
        busy = busy - 1;
        if (busy == 0 && userOp) begin
          doneE = 1;
          if (!opWrite) rdataE = opData;
        end
      end else if (pend) begin
        busy   = (open ? PRE : 0) + ACT + PRE;
        open   = 0;
        pend   = 0;
        userOp = 0;
        ctxTag = "R7";
      end else if (reqValid) begin
        if (open && oRow == int'(reqRow)) begin
          busy = 1; ctxTag = "R2";
        end else if (open) begin
          busy = PRE + ACT + 1; ctxTag = "R4 R5";
        end else begin
          busy = ACT + 1; ctxTag = "R3";
        end
        open    = 1;
        oRow    = int'(reqRow);
        userOp  = 1;
        opWrite = reqWrite;
        if (reqWrite) mem[reqRow][reqCol] = int'(reqWdata);
        else          opData = mem[reqRow][reqCol];
      end
      if (tick == INTV - 1) begin
        tick = 0;
        pend = 1;
      end else begin
        tick = tick + 1;
      end
      readyE = (busy == 0) && !pend;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (reqReady !== readyE) begin
      errors++;
      $display("FAIL %s reqReady actual %0b expected %0b at %0t", ctxTag, reqReady, readyE, $time);
    end
    checks++;
    if (rspValid !== doneE) begin
      errors++;
      $display("FAIL R8 rspValid actual %0b expected %0b at %0t", rspValid, doneE, $time);
    end
    checks++;
    if (int'(rspRdata) !== rdataE) begin
      errors++;
      $display("FAIL %s R6 R8 rspRdata actual %0h expected %0h at %0t", phaseTag, rspRdata, rdataE, $time);
    end
  end

  task automatic issue(input bit w, input int r, input int c, input int d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w;
    reqRow = 4'(r); reqCol = 3'(c); reqWdata = 8'(d);
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: cold store reads as zero, then R3 closed-row miss timing
    phaseTag = "R1";
    issue(0, 3, 2, 0);
    // R6 and R2: write then read on the open row
    phaseTag = "R6";
    issue(1, 3, 2, 8'hA5);
    issue(0, 3, 2, 0);
    issue(1, 3, 5, 8'h5A);
    // R4: switch rows, then come back: write-back must have kept both words
    issue(1, 5, 1, 8'h3C);
    issue(0, 3, 2, 0);
    issue(0, 3, 5, 0);
    issue(0, 5, 1, 0);
    idle(4);

    // R9: a request held while busy must leave no trace
    phaseTag = "R9";
    issue(1, 7, 0, 8'h11);
    reqValid = 1'b1; reqWrite = 1'b1; reqRow = 4'd7; reqCol = 3'd0; reqWdata = 8'h99;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b0;
    issue(0, 7, 0, 0);
    idle(4);

    // R7: fill every row, idle across many refreshes, read everything back
    phaseTag = "R7";
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c += 3)
        issue(1, r, c, (r * 16 + c + 7) & 8'hFF);
    idle(INTV * ROWS + 20);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c += 3)
        issue(0, r, c, 0);

    // mixed traffic on a few rows: hits, misses, refresh collisions, ignored inputs
    phaseTag = "R2 R9";
    for (int i = 0; i < 2500; i++) begin
      @(negedge clk);
      reqValid = ($urandom % 10) < 7;
      reqWrite = $urandom % 2;
      reqRow   = 4'($urandom % 4);
      reqCol   = 3'($urandom % COLS);
      reqWdata = 8'($urandom);
    end
    reqValid = 1'b0;
    idle(20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule